// File: doc/BRIEF.md
# Multi-field binary-polynomial reducer

This block takes the double-width result of a carry-less polynomial multiplication and brings it back into one of three fixed binary fields, GF(2^163), GF(2^233) or GF(2^283). Each field has its own fixed XOR network, built from that field's irreducible polynomial. A two-bit select code picks which network's residue reaches the output. The residue is zero-extended to 283 bits, so one datapath width serves all three key sizes.

The fold works downward from the highest product bit. Because x^m is congruent to the polynomial's lower terms, each set bit at position m or above is cleared and its weight is added back at the positions of those lower terms. For every supported polynomial, the second-highest exponent is below m/2, so each folded bit lands at least one place below the bit it came from. The result is registered once for timing. A parameter can remove the register.

Top module: `gf2_multi_reducer`

## Requirements
- R1: With select code 2'b00, the output equals the product modulo x^163 + x^7 + x^6 + x^3 + 1.
- R2: With select code 2'b01, the output equals the product modulo x^233 + x^74 + 1.
- R3: With select code 2'b10, the output equals the product modulo x^283 + x^12 + x^7 + x^5 + 1.
- R4: Select code 2'b11 gives an all-zero output for any product.
- R5: Output bits at and above m of the selected field are always zero.
- R6: For field m, only product bits [2m-2:0] are used. Bits above 2m-2 have no effect on the output.
- R7: A product with no bit set at or above m is passed through unchanged.
- R8: The output is registered with one cycle of latency, and it reads zero while reset is active.
- R9: A product equal to x^m alone reduces to exactly the lower terms of that field's polynomial.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Field select: 00 = 163, 01 = 233, 10 = 283, 11 = none |
| prod_i | input | 565 | Product word; bits [2m-2:0] are significant for field m |
| res_o | output | 283 | Reduced residue, zero-extended |

## Verification
The assertions assume that the select code and the product are held from one rising edge to the next. This lets the registered output be related to the previous cycle's inputs through $past. They also assume that the output register is present. The bench changes inputs only on falling edges, so every sampled pair is stable across the capturing edge. Random products are masked to 2m-1 bits, except in the cases that deliberately fill the unused upper bits to show that those bits are ignored.

// File: rtl/gf2_red_pkg.sv
package gf2_red_pkg;

    localparam int NFIELD = 3;
    localparam int W_MAX  = 283;
    localparam int P_W    = 2 * W_MAX - 1;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_F163 = 2'b00,
        SEL_F233 = 2'b01,
        SEL_F283 = 2'b10,
        SEL_NONE = 2'b11
    } field_sel_e;

    // field degree and middle exponents; NT counts the middle terms (1 or 3)
    localparam int FIELD_M  [NFIELD] = '{163, 233, 283};
    localparam int FIELD_NT [NFIELD] = '{3,   1,   3};
    localparam int FIELD_K1 [NFIELD] = '{7,   74,  12};
    localparam int FIELD_K2 [NFIELD] = '{6,   0,   7};
    localparam int FIELD_K3 [NFIELD] = '{3,   0,   5};

    // lower-term mask of r(x): x^m is congruent to this value
    function automatic logic [W_MAX-1:0] tail_mask(input int nt, input int k1,
                                                   input int k2, input int k3);
        logic [W_MAX-1:0] t;
        t     = '0;
        t[0]  = 1'b1;
        t[k1] = 1'b1;
        if (nt == 3) begin
            t[k2] = 1'b1;
            t[k3] = 1'b1;
        end
        return t;
    endfunction

    typedef struct packed {
        logic             arm;
        logic [W_MAX-1:0] res;
    } red_state_t;

endpackage

// File: rtl/gf2_fold_red.sv
module gf2_fold_red #(
    parameter int               M     = 163,
    parameter int               W_OUT = 283,
    parameter logic [W_OUT-1:0] TAIL  = '0
) (
    input  logic [2*M-2:0]   prod_i,
    output logic [W_OUT-1:0] res_o
);

    localparam int TOP = 2 * M - 2;

    // top-down fold: each bit >= M is cleared and TAIL is added M places lower
    always_comb begin
        logic [TOP:0] acc;
        acc = prod_i;
        for (int i = TOP; i >= M; i--) begin
            if (acc[i]) begin
                acc[i]         = 1'b0;
                acc[i-M +: M]  = acc[i-M +: M] ^ TAIL[M-1:0];
            end
        end
        res_o          = '0;
        res_o[M-1:0]   = acc[M-1:0];
    end

endmodule

// File: rtl/gf2_field_mux.sv
module gf2_field_mux #(
    parameter int NF    = 3,
    parameter int W     = 283,
    parameter int SEL_W = 2
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic [W-1:0]     cand_i [NF],
    output logic [W-1:0]     res_o
);

    // codes at or beyond NF select nothing and leave zero
    always_comb begin
        res_o = '0;
        for (int f = 0; f < NF; f++) begin
            if (sel_i == f[SEL_W-1:0]) res_o = cand_i[f];
        end
    end

endmodule

// File: rtl/gf2_multi_reducer.sv
module gf2_multi_reducer
    import gf2_red_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [P_W-1:0]   prod_i,
    output logic [W_MAX-1:0] res_o
);

    logic [W_MAX-1:0] cand [NFIELD];
    logic [W_MAX-1:0] mux_res;
    red_state_t       state_d, state_q;

    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        localparam int               FM   = FIELD_M[g];
        localparam logic [W_MAX-1:0] TMSK = tail_mask(FIELD_NT[g], FIELD_K1[g],
                                                      FIELD_K2[g], FIELD_K3[g]);
        gf2_fold_red #(
            .M     (FM),
            .W_OUT (W_MAX),
            .TAIL  (TMSK)
        ) u_red (
            .prod_i (prod_i[2*FM-2:0]),
            .res_o  (cand[g])
        );
    end

    gf2_field_mux #(
        .NF    (NFIELD),
        .W     (W_MAX),
        .SEL_W (SEL_W)
    ) u_mux (
        .sel_i  (sel_i),
        .cand_i (cand),
        .res_o  (mux_res)
    );

    always_comb begin
        state_d     = state_q;
        state_d.arm = 1'b1;
        state_d.res = mux_res;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    if (REG_OUT) begin : g_reg
        assign res_o = state_q.res;

        // R4
        bad_sel_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (state_q.arm && $past(sel_i) == SEL_NONE) |-> res_o == '0);

        // R5
        f163_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (state_q.arm && $past(sel_i) == SEL_F163) |-> res_o[W_MAX-1:163] == '0);

        // R7
        f283_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (state_q.arm && $past(sel_i) == SEL_F283 && $past(prod_i[P_W-1:W_MAX]) == '0)
            |-> res_o == $past(prod_i[W_MAX-1:0]));

        // R9
        f233_fold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (state_q.arm && $past(sel_i) == SEL_F233 && $past(prod_i) == (P_W'(1) << 233))
            |-> res_o == ((W_MAX'(1) << 74) | W_MAX'(1)));
    end else begin : g_comb
        assign res_o = mux_res;
    end

endmodule

// File: tb/gf2_multi_reducer_tb.sv
`timescale 1ns/1ps
module gf2_multi_reducer_tb;

    localparam int W = 283;
    localparam int PW = 565;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    sel = 2'b00;
    logic [PW-1:0] prod = '0;
    logic [W-1:0]  res;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 1'b0;
    item_t sb_q[$];

    always #2 clk = ~clk;

    gf2_multi_reducer u_dut (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .sel_i  (sel),
        .prod_i (prod),
        .res_o  (res)
    );

    function automatic int deg_of(logic [1:0] s);
        case (s)
            2'b00:   return 163;
            2'b01:   return 233;
            default: return 283;
        endcase
    endfunction

    // bit-serial long division (Horner form) over bits [2m-2:0] only
    function automatic logic [W-1:0] ref_red(logic [1:0] s, logic [PW-1:0] c);
        logic [W:0] r, poly;
        int m;
        if (s == 2'b11) return '0;
        m = deg_of(s);
        poly = '0; poly[m] = 1'b1; poly[0] = 1'b1;
        case (m)
            163:     begin poly[7] = 1'b1; poly[6] = 1'b1; poly[3] = 1'b1; end
            233:     poly[74] = 1'b1;
            default: begin poly[12] = 1'b1; poly[7] = 1'b1; poly[5] = 1'b1; end
        endcase
        r = '0;
        for (int i = 2 * m - 2; i >= 0; i--) begin
            r = {r[W-1:0], c[i]};
            if (r[m]) r = r ^ poly;
        end
        return r[W-1:0];
    endfunction

    function automatic logic [PW-1:0] rnd_wide();
        logic [575:0] t;
        for (int w = 0; w < 18; w++) t[w*32 +: 32] = $urandom;
        return t[PW-1:0];
    endfunction

    function automatic logic [PW-1:0] keep_low(logic [PW-1:0] p, int n);
        logic [PW-1:0] k;
        for (int i = 0; i < PW; i++) k[i] = (i < n) ? p[i] : 1'b0;
        return k;
    endfunction

    task automatic send(logic [1:0] s, logic [PW-1:0] p, string tag);
        item_t it;
        @(negedge clk);
        sel  = s;
        prod = p;
        it.exp = ref_red(s, p);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // monitor: result of inputs captured at this edge, sampled 1 ns later
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_chk++;
                if (res !== it.exp) begin
                    n_err++;
                    $display("FAIL %s: res=%h expected=%h", it.tag, res, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        logic [1:0] s;
        // R8: output is zero during reset
        repeat (3) @(negedge clk);
        prod = rnd_wide();
        sel  = 2'b01;
        @(negedge clk);
        n_chk++;
        if (res !== '0) begin
            n_err++;
            $display("FAIL R8: res=%h expected=0", res);
        end
        rst_n = 1'b1;

        // R9: x^m alone folds to the lower terms
        for (int f = 0; f < 3; f++) begin
            logic [PW-1:0] p;
            s = 2'(f);
            p = '0; p[deg_of(s)] = 1'b1;
            send(s, p, "R9");
        end
        // R7: product already below degree m, and zero
        for (int f = 0; f < 3; f++) begin
            s = 2'(f);
            send(s, keep_low(rnd_wide(), deg_of(s)), "R7");
            send(s, '0, "R7");
        end
        // R1/R2/R3: random products per field
        for (int k = 0; k < 25; k++) send(2'b00, keep_low(rnd_wide(), 2 * 163 - 1), "R1");
        for (int k = 0; k < 25; k++) send(2'b01, keep_low(rnd_wide(), 2 * 233 - 1), "R2");
        for (int k = 0; k < 25; k++) send(2'b10, rnd_wide(), "R3");
        // R5: all-ones low span, upper output bits must stay zero
        send(2'b00, keep_low('1, 2 * 163 - 1), "R5");
        send(2'b01, keep_low('1, 2 * 233 - 1), "R5");
        send(2'b10, '1, "R5");
        // R6: garbage above 2m-2 is ignored
        for (int k = 0; k < 5; k++) send(2'b00, rnd_wide(), "R6");
        for (int k = 0; k < 5; k++) send(2'b01, rnd_wide(), "R6");
        // R4: unused select code
        for (int k = 0; k < 4; k++) send(2'b11, rnd_wide(), "R4");
        send(2'b11, '1, "R4");
        // alternate fields back to back (R8 one-cycle latency)
        for (int k = 0; k < 6; k++) send(2'(k % 3), rnd_wide(), "R8");

        repeat (4) @(posedge clk);
        #2;
        done = 1'b1;
        finish_run();
    end

endmodule